// File: doc/BRIEF.md
# Time-Slotted Video SRAM Arbiter

This block lets a video scanout engine and a host write path share one asynchronous SRAM without a request/grant handshake. Ownership follows a fixed eight-slot schedule, one slot per pixel clock. The slot index is the low three bits of the horizontal column counter, so the schedule repeats for every group of eight pixels. When bit 2 of the index is clear (slots 0 to 3), the video engine owns the bus. It places its fetch address on the SRAM and reads up to `N_READS` bytes for the next group. When bit 2 is set (slots 4 to 7), the block drives the latched host address and data for the whole half-group. It pulses write enable only in one inner slot, which leaves a guard slot at each end of the window.

The host loads its address and data at any time through a one-cycle load strobe. A load made outside the write window takes effect at once. A load made during the window is held in a staging register and commits only after the window has ended, so the SRAM address and data never move under an active strobe. The bytes fetched in the read slots are gathered and handed to the pixel shifter as one word during slot 7.

The column counter is expected to advance by one on every clock. `WR_SLOT` must be 1 or 2, and `N_READS` may be 2, 3 or 4.

Top module: `vsa_arbiter`

## Requirements
- R1: While `col_lo[2]` is 1, `sram_dq_oe` is 1 and `sram_addr`/`sram_dout` carry the committed host address and data, unchanged across slots 4 to 7.
- R2: While `col_lo[2]` is 0, `sram_dq_oe` is 0 and `sram_addr` equals `vid_addr`.
- R3: `sram_oe_n` is low exactly in slots 0 to `N_READS`-1 (slots 0 to 3 by default) and high in every other slot.
- R4: `sram_we_n` is low for at most one slot per group. That slot is `4+WR_SLOT` (slot 5 by default), and the strobe happens only when a host write is pending. It is never low in slot 4 or 7.
- R5: `sram_ce_n` is low in every cycle outside reset.
- R6: A load with `host_ld`=1 while `col_lo[2]`=0 commits at that clock edge, and the write is performed in the next write window.
- R7: A load during the write window leaves the current window's address and data untouched. It commits at the first clock edge that ends a video-half slot and is written in the window after that.
- R8: A performed write clears the pending state, so a group with no new load produces no write strobe.
- R9: A new load replaces a committed write that has not yet been performed; only the newer one reaches the SRAM.
- R10: The byte on `sram_din` in read slot i is captured at the edge ending that slot. During slot 7, `pix_valid` is 1 and `pix_data[8i+7:8i]` holds the byte from slot i; `pix_valid` is 0 in all other slots.
- R11: While `rst` is 1, `sram_we_n`, `sram_oe_n` and `sram_ce_n` are high and `sram_dq_oe` is 0. Reset discards any pending or staged write and clears `pix_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| col_lo | input | 3 | Low three bits of the column counter (slot index) |
| vid_addr | input | ADDR_W | Video fetch address for the current slot |
| host_ld | input | 1 | One-cycle host load strobe |
| host_addr | input | ADDR_W | Host write address |
| host_data | input | DATA_W | Host write data |
| sram_addr | output | ADDR_W | SRAM address bus |
| sram_dout | output | DATA_W | Data driven toward the SRAM |
| sram_dq_oe | output | 1 | Enable for driving the SRAM data bus |
| sram_din | input | DATA_W | Data returned by the SRAM |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| pix_data | output | N_READS*DATA_W | Fetched bytes for the pixel shifter |
| pix_valid | output | 1 | Fetched bytes are presented (slot 7) |

## Verification
The assertions hold these on every cycle:
- the write strobe stays inside the inner slots and lasts a single slot;
- read and write strobes are never active together with the data driver;
- address and data stay frozen through the write window;
- chip enable is present outside reset, and all strobes are quiet during reset.

Other behaviour needs a reference model and the bench's scenarios. This covers:
- which host value finally lands in memory when loads arrive before, during or after a window;
- replacement of an unperformed write;
- a reset discarding a pending write;
- correct placement of each fetched byte in the pixel word.

// File: rtl/vsa_pkg.sv
package vsa_pkg;

    typedef logic [2:0] slot_t;

    typedef enum logic {
        OWN_VIDEO = 1'b0,
        OWN_HOST  = 1'b1
    } owner_e;

    typedef struct packed {
        owner_e owner;     // who drives address/data this slot
        logic   rd;        // video read slot
        logic   wr_pt;     // slot where the write strobe may fire
        logic   cap_last;  // last slot before presentation
        logic   show;      // presentation slot
    } slot_ctl_t;

endpackage

// File: rtl/vsa_slot_dec.sv
module vsa_slot_dec
    import vsa_pkg::*;
#(
    parameter int N_READS = 4,
    parameter int WR_SLOT = 1
) (
    input  logic [2:0] slot,
    output slot_ctl_t  ctl
);
    localparam int HALF = 4;
    localparam logic [1:0] WR_IDX = 2'(WR_SLOT);

    logic [HALF-1:0] rd_mask;

    for (genvar g = 0; g < HALF; g++) begin : g_rd
        assign rd_mask[g] = (g < N_READS);
    end

    always_comb begin
        ctl          = '0;
        ctl.owner    = slot[2] ? OWN_HOST : OWN_VIDEO;
        ctl.rd       = !slot[2] && rd_mask[slot[1:0]];
        ctl.wr_pt    = slot[2] && (slot[1:0] == WR_IDX);
        ctl.cap_last = (slot == 3'd6);
        ctl.show     = (slot == 3'd7);
    end

endmodule

// File: rtl/vsa_host_latch.sv
module vsa_host_latch #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_window,
    input  logic              strobe_done,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              pend
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              pend;
        logic [ADDR_W-1:0] stg_addr;
        logic [DATA_W-1:0] stg_data;
        logic              stg_vld;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (strobe_done) begin
            lat_d.pend = 1'b0;
        end
        if (ld) begin
            if (!in_window) begin
                lat_d.addr    = ld_addr;
                lat_d.data    = ld_data;
                lat_d.pend    = 1'b1;
                lat_d.stg_vld = 1'b0;
            end else begin
                lat_d.stg_addr = ld_addr;
                lat_d.stg_data = ld_data;
                lat_d.stg_vld  = 1'b1;
            end
        end else if (!in_window && lat_q.stg_vld) begin
            lat_d.addr    = lat_q.stg_addr;
            lat_d.data    = lat_q.stg_data;
            lat_d.pend    = 1'b1;
            lat_d.stg_vld = 1'b0;
        end
        if (rst) begin
            lat_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        lat_q <= lat_d;
    end

    assign wr_addr = lat_q.addr;
    assign wr_data = lat_q.data;
    assign pend    = lat_q.pend;

endmodule

// File: rtl/vsa_fetch.sv
module vsa_fetch #(
    parameter int DATA_W  = 8,
    parameter int N_READS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd,
    input  logic [1:0]                slot_lo,
    input  logic                      cap_last,
    input  logic [DATA_W-1:0]         din,
    output logic [N_READS*DATA_W-1:0] pix
);
    localparam int PIX_W = N_READS * DATA_W;

    typedef struct packed {
        logic [N_READS-1:0][DATA_W-1:0] grab;
        logic [PIX_W-1:0]               pix;
    } fet_t;

    fet_t fet_d, fet_q;

    always_comb begin
        fet_d = fet_q;
        for (int i = 0; i < N_READS; i++) begin
            if (rd && (32'(slot_lo) == i)) begin
                fet_d.grab[i] = din;
            end
        end
        if (cap_last) begin
            fet_d.pix = fet_q.grab;
        end
        if (rst) begin
            fet_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        fet_q <= fet_d;
    end

    assign pix = fet_q.pix;

endmodule

// File: rtl/vsa_arbiter.sv
module vsa_arbiter
    import vsa_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    parameter int N_READS = 4,
    parameter int WR_SLOT = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [2:0]                col_lo,
    input  logic [ADDR_W-1:0]         vid_addr,
    input  logic                      host_ld,
    input  logic [ADDR_W-1:0]         host_addr,
    input  logic [DATA_W-1:0]         host_data,
    output logic [ADDR_W-1:0]         sram_addr,
    output logic [DATA_W-1:0]         sram_dout,
    output logic                      sram_dq_oe,
    input  logic [DATA_W-1:0]         sram_din,
    output logic                      sram_ce_n,
    output logic                      sram_oe_n,
    output logic                      sram_we_n,
    output logic [N_READS*DATA_W-1:0] pix_data,
    output logic                      pix_valid
);
    slot_ctl_t         ctl;
    logic              in_win;
    logic              we_fire;
    logic              pend;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    vsa_slot_dec #(
        .N_READS (N_READS),
        .WR_SLOT (WR_SLOT)
    ) u_dec (
        .slot (col_lo),
        .ctl  (ctl)
    );

    assign in_win  = (ctl.owner == OWN_HOST);
    assign we_fire = !rst && ctl.wr_pt && pend;

    vsa_host_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_lat (
        .clk         (clk),
        .rst         (rst),
        .in_window   (in_win),
        .strobe_done (we_fire),
        .ld          (host_ld),
        .ld_addr     (host_addr),
        .ld_data     (host_data),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .pend        (pend)
    );

    vsa_fetch #(
        .DATA_W  (DATA_W),
        .N_READS (N_READS)
    ) u_fet (
        .clk      (clk),
        .rst      (rst),
        .rd       (ctl.rd && !rst),
        .slot_lo  (col_lo[1:0]),
        .cap_last (ctl.cap_last),
        .din      (sram_din),
        .pix      (pix_data)
    );

    always_comb begin
        sram_addr  = in_win ? wr_addr : vid_addr;
        sram_dout  = wr_data;
        sram_dq_oe = in_win && !rst;
        sram_ce_n  = rst;
        sram_oe_n  = !(ctl.rd && !rst);
        sram_we_n  = !we_fire;
        pix_valid  = ctl.show && !rst;
    end

endmodule

// File: rtl/vsa_chk.sv
module vsa_chk #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        col_lo,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_dout,
    input logic              sram_dq_oe,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic              pix_valid
);
    // R4
    we_inner_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (col_lo[2] && col_lo[1:0] != 2'd0 && col_lo[1:0] != 2'd3));

    // R4
    we_single_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |=> sram_we_n);

    // R3
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (!sram_dq_oe && sram_we_n));

    // R1
    win_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (col_lo[2] && col_lo[1:0] != 2'd0 && !$past(rst))
            |-> ($stable(sram_addr) && $stable(sram_dout) && sram_dq_oe));

    // R5
    ce_on_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_ce_n);

    // R11
    rst_quiet_chk: assert property (@(posedge clk)
        rst |-> (sram_we_n && sram_oe_n && sram_ce_n && !sram_dq_oe));

    // R10
    pix_slot_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (col_lo == 3'd7));
endmodule

bind vsa_arbiter vsa_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .col_lo     (col_lo),
    .sram_addr  (sram_addr),
    .sram_dout  (sram_dout),
    .sram_dq_oe (sram_dq_oe),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .pix_valid  (pix_valid)
);

// File: tb/tb_vsa_arbiter.sv
module tb_vsa_arbiter;
    localparam int PERIOD  = 10;
    localparam int ADDR_W  = 13;
    localparam int DATA_W  = 8;
    localparam int N_READS = 4;
    localparam int WR_SLOT = 1;
    localparam int PIX_W   = N_READS * DATA_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        col_lo = 3'd0;
    logic [ADDR_W-1:0] vid_addr = '0;
    logic              host_ld = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_data = '0;
    logic [ADDR_W-1:0] sram_addr;
    logic [DATA_W-1:0] sram_dout;
    logic              sram_dq_oe;
    logic [DATA_W-1:0] sram_din = '0;
    logic              sram_ce_n, sram_oe_n, sram_we_n;
    logic [PIX_W-1:0]  pix_data;
    logic              pix_valid;

    vsa_arbiter #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .N_READS (N_READS), .WR_SLOT (WR_SLOT)
    ) dut (
        .clk (clk), .rst (rst), .col_lo (col_lo), .vid_addr (vid_addr),
        .host_ld (host_ld), .host_addr (host_addr), .host_data (host_data),
        .sram_addr (sram_addr), .sram_dout (sram_dout), .sram_dq_oe (sram_dq_oe),
        .sram_din (sram_din), .sram_ce_n (sram_ce_n), .sram_oe_n (sram_oe_n),
        .sram_we_n (sram_we_n), .pix_data (pix_data), .pix_valid (pix_valid)
    );

    always #(PERIOD/2) clk = ~clk;

    // external SRAM contents, written only by observed strobes
    bit [7:0] mem [int];
    int   errors = 0;
    int   checks = 0;
    int   strobes = 0;
    bit   finished = 0;
    logic [2:0] nxt_col = 3'd0;

    // reference model state
    int          m_addr = 0, m_data = 0;
    bit          m_pend = 0;
    int          stg_a[$], stg_d[$];
    logic [7:0]  m_grab [N_READS];
    logic [PIX_W-1:0] m_pix = '0;

    function automatic logic [7:0] mem_get(int a);
        if (mem.exists(a)) return mem[a];
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // compare this cycle against the model, then advance the model past the edge
    task automatic step_model();
        logic [2:0] s;
        bit w, ew;
        s = col_lo;
        w = s[2];
        ew = 0;
        if (!sram_we_n && sram_dq_oe) begin
            mem[int'(sram_addr)] = sram_dout;
            strobes++;
        end
        if (rst) begin
            chk(sram_we_n == 1'b1, "R11 we_n in reset", sram_we_n, 1);
            chk(sram_oe_n == 1'b1, "R11 oe_n in reset", sram_oe_n, 1);
            chk(sram_ce_n == 1'b1, "R11 ce_n in reset", sram_ce_n, 1);
            chk(sram_dq_oe == 1'b0, "R11 dq_oe in reset", sram_dq_oe, 0);
            m_addr = 0; m_data = 0; m_pend = 0;
            stg_a.delete(); stg_d.delete();
            for (int i = 0; i < N_READS; i++) m_grab[i] = '0;
            m_pix = '0;
            return;
        end
        ew = w && (int'(s[1:0]) == WR_SLOT) && m_pend;
        chk(sram_ce_n == 1'b0, "R5 ce_n", sram_ce_n, 0);
        chk(sram_dq_oe == w, w ? "R1 dq_oe" : "R2 dq_oe", sram_dq_oe, w);
        if (w) begin
            chk(int'(sram_addr) == m_addr, "R1/R6/R7/R9 window addr", sram_addr, m_addr);
            chk(int'(sram_dout) == m_data, "R1/R6/R7/R9 window data", sram_dout, m_data);
        end else begin
            chk(sram_addr == vid_addr, "R2 video addr", sram_addr, vid_addr);
        end
        chk(sram_oe_n == !(int'(s) < N_READS), "R3 oe_n", sram_oe_n, !(int'(s) < N_READS));
        chk(sram_we_n == !ew, "R4/R8 we_n", sram_we_n, !ew);
        chk(pix_valid == (s == 3'd7), "R10 pix_valid", pix_valid, s == 3'd7);
        chk(pix_data == m_pix, "R10 pix_data", pix_data, m_pix);
        // next state
        if (ew) m_pend = 0;
        if (host_ld) begin
            if (!w) begin
                m_addr = int'(host_addr); m_data = int'(host_data); m_pend = 1;
                stg_a.delete(); stg_d.delete();
            end else begin
                stg_a.delete(); stg_d.delete();
                stg_a.push_back(int'(host_addr)); stg_d.push_back(int'(host_data));
            end
        end else if (!w && stg_a.size() > 0) begin
            m_addr = stg_a.pop_front(); m_data = stg_d.pop_front(); m_pend = 1;
        end
        if (int'(s) < N_READS) m_grab[s] = mem_get(int'(vid_addr));
        if (s == 3'd6) begin
            for (int i = 0; i < N_READS; i++) m_pix[i*8 +: 8] = m_grab[i];
        end
    endtask

    task automatic cyc(bit ld, int a, int d, bit r);
        @(posedge clk);
        #1;
        rst       = r;
        col_lo    = nxt_col;
        nxt_col   = nxt_col + 3'd1;
        host_ld   = ld;
        host_addr = ADDR_W'(a);
        host_data = DATA_W'(d);
        vid_addr  = ADDR_W'($urandom);
        #1;
        sram_din  = !sram_oe_n ? mem_get(int'(sram_addr)) : 8'hEE;
        @(negedge clk);
        step_model();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
    endtask

    task automatic idle_until(int s);
        while (int'(nxt_col) != s) cyc(0, 0, 0, 0);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int s0;
        // R11: reset state
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1);
        // R8: nothing pending, no strobe
        idle(16);
        chk(strobes == 0, "R8 no strobe without load", strobes, 0);
        // R6: load outside window
        idle_until(1);
        cyc(1, 'h123, 'hA5, 0);
        idle(16);
        chk(mem.exists('h123) && mem['h123] == 8'hA5, "R6 write landed", mem_get('h123), 'hA5);
        chk(strobes == 1, "R6/R8 one strobe", strobes, 1);
        // R7: load during window with older write pending
        idle_until(2);
        cyc(1, 'h050, 'h11, 0);
        idle_until(4);
        cyc(1, 'h051, 'h22, 0);
        idle(16);
        chk(mem_get('h050) == 8'h11, "R7 older write kept", mem_get('h050), 'h11);
        chk(mem_get('h051) == 8'h22, "R7 staged write landed", mem_get('h051), 'h22);
        chk(strobes == 3, "R7 strobe count", strobes, 3);
        // R7: load in strobe slot and after it
        idle_until(5);
        cyc(1, 'h060, 'h33, 0);
        idle_until(6);
        cyc(1, 'h061, 'h34, 0);
        idle(16);
        chk(mem_get('h061) == 8'h34, "R7 late window load", mem_get('h061), 'h34);
        chk(!mem.exists('h060), "R7 replaced staged load", mem.exists('h060), 0);
        // R9: replace unperformed write
        idle_until(0);
        cyc(1, 'h200, 'h44, 0);
        cyc(1, 'h201, 'h45, 0);
        idle(16);
        chk(!mem.exists('h200), "R9 replaced write absent", mem.exists('h200), 0);
        chk(mem_get('h201) == 8'h45, "R9 newer write landed", mem_get('h201), 'h45);
        // R11: reset discards pending write
        idle_until(2);
        cyc(1, 'h300, 'h55, 0);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        idle(16);
        chk(!mem.exists('h300), "R11 pending dropped", mem.exists('h300), 0);
        // mixed traffic
        for (int g = 0; g < 60; g++) begin
            s0 = int'($urandom % 8);
            for (int k = 0; k < 8; k++) begin
                if (k == s0) cyc(1, int'($urandom % 1024), int'($urandom % 256), 0);
                else cyc(0, 0, 0, 0);
            end
        end
        idle(8);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule